// File: doc/BRIEF.md
# Warm Reset Strap Sequencer

This block produces a warm reset for a processor bus agent and drives the configuration straps that the agent latches when its reset is released. It runs entirely in the bus-clock domain. A rising edge on the warm-reset request starts a sequence. Reset is asserted and the 5-bit bus-ratio strap is driven on the same edge. Reset is then held low for a minimum time that is derived from a clock-frequency parameter. The remaining configuration straps are driven for a fixed number of clocks before reset is released. Both strap groups are held for a bounded number of clocks after release, and then their drivers are turned off.

Strap values are captured when the sequence starts, so the pins stay stable even if the programmed values change meanwhile. Power-good must stay high for the whole sequence. If it drops, the sequence is abandoned at once, reset stays asserted, the strap drivers are turned off and a sticky error flag is set. A one-clock done pulse marks the release of the strap drivers. A busy output covers the span from the accepted request to that pulse.

Top module: `warm_rst_seq`

## Requirements
- R1: Once the block reset is released with power-good high, reset_n_o is high within two clocks, and both output-enables, busy_o, done_o and pg_err_o are low.
- R2: A rising edge on warm_req_i while idle and with power-good high asserts reset_n_o low, raises ratio_oe_o and raises busy_o, all on the third rising clock edge after the request rises (two synchronizer stages plus the state register). cfg_oe_o stays low on that edge.
- R3: reset_n_o stays low for exactly RST_CLKS clocks, where RST_CLKS = floor(CLK_HZ * MIN_RST_US / 1e6). It is released from a register clocked by the bus clock.
- R4: cfg_oe_o rises exactly PRE_CLKS clocks before the clock on which reset_n_o rises, and stays high from then on while the straps are held.
- R5: Both output-enables stay high for exactly HOLD_CLKS clocks (2 or 3) after reset_n_o rises, and then drop together.
- R6: done_o is high for exactly one clock, on the clock where the output-enables drop. busy_o is low from that clock onwards.
- R7: A further request edge while a sequence runs has no effect: the timing of that sequence is unchanged and no second sequence follows.
- R8: While power-good is low and no sequence runs, reset_n_o is held low and a request edge is ignored. The request is not remembered after power-good returns.
- R9: If power-good is low while a sequence runs, then on the next clock busy_o and both output-enables are low, reset_n_o is low and pg_err_o is high.
- R10: pg_err_o stays high until the block reset. After an abort, reset_n_o stays low even once power-good returns, until a later sequence releases reset.
- R11: ratio_o and cfg_o carry the values of ratio_i and cfg_i captured on the start edge. Changes to those inputs during a sequence do not reach the outputs.
- R12: A request held high for longer than one sequence starts exactly one sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| warm_req_i | input | 1 | Warm-reset request, asynchronous, rising edge starts a sequence |
| pwr_good_i | input | 1 | Power-good, synchronous to clk, must stay high during a sequence |
| ratio_i | input | RATIO_W | Programmed bus-ratio strap value |
| cfg_i | input | CFG_W | Programmed values for the other configuration straps |
| reset_n_o | output | 1 | Active-low warm reset to the bus agent |
| ratio_o | output | RATIO_W | Bus-ratio strap data (zero when not driven) |
| ratio_oe_o | output | 1 | Output-enable for the bus-ratio straps |
| cfg_o | output | CFG_W | Other strap data (zero when not driven) |
| cfg_oe_o | output | 1 | Output-enable for the other straps |
| busy_o | output | 1 | High from the accepted request until the done pulse |
| done_o | output | 1 | One-clock pulse when the strap drivers are released |
| pg_err_o | output | 1 | Sticky flag: power-good was lost during a sequence |

## Verification
The bench builds the block with CLK_HZ = 50000, which makes the minimum reset width 50 clocks instead of hundreds of thousands. Every sequence can therefore be traced clock by clock, from the start edge to the driver release. HOLD_CLKS is set to 3, its upper bound, so that a release one clock early or late shows up as a mismatch of the output-enables and the done pulse. PRE_CLKS keeps its default of 4, and the strap widths are 5 and 6 bits, wide enough for distinct patterns that expose swapped or late-captured values.

// File: rtl/wrs_pkg.sv
// Package: shared types for the warm reset strap sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package wrs_pkg;

    // Sequencer phases, in the order a full sequence walks them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // nothing running, drivers off
        ST_RATIO = 3'd1,   // reset asserted, bus-ratio strap driven
        ST_HOLD  = 3'd2,   // minimum reset width being counted
        ST_PRE   = 3'd3,   // other straps driven ahead of release
        ST_REL   = 3'd4,   // reset released, straps held
        ST_KEEP  = 3'd5    // remaining strap hold clocks
    } wrs_state_e;

endpackage

// File: rtl/wrs_req_sync.sv
// Module: wrs_req_sync
// Brings an asynchronous request level into the bus-clock domain through
// STAGES flops and emits a one-clock pulse on its rising edge.
// Assumes: STAGES >= 2; the request is held at least STAGES+1 clocks.
module wrs_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);

    logic [STAGES:0] sh_q;

    // Shift the request through the synchronizer plus one edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], req_i};
        end
    end

    // Rising edge of the synchronized level.
    always_comb begin
        pulse_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

endmodule

// File: rtl/wrs_timer.sv
// Module: wrs_timer
// Down-counter for phase lengths: loaded with (length - 1) on phase entry,
// it reports zero on the last clock of the phase.
// Assumes: load has priority over counting; the counter rests at zero.
module wrs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Terminal count flag.
    always_comb begin
        zero_o = (cnt_q == '0);
    end

endmodule

// File: rtl/wrs_strap_out.sv
// Module: wrs_strap_out
// Captures the programmed strap values at sequence start and drives the two
// strap groups with registered output-enables; data reads zero when disabled.
// Assumes: capture_i is a one-clock pulse coinciding with ratio_en_i rising.
module wrs_strap_out #(
    parameter int RATIO_W = 5,
    parameter int CFG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [CFG_W-1:0]   cfg_i,
    input  logic               ratio_en_i,
    input  logic               cfg_en_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               ratio_oe_o,
    output logic [CFG_W-1:0]   cfg_o,
    output logic               cfg_oe_o
);

    logic [RATIO_W-1:0] ratio_q;
    logic [CFG_W-1:0]   cfg_q;
    logic               ratio_oe_q;
    logic               cfg_oe_q;

    // Hold the strap values taken on the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= '0;
            cfg_q   <= '0;
        end else if (capture_i) begin
            ratio_q <= ratio_i;
            cfg_q   <= cfg_i;
        end
    end

    // Register the output-enables so the pins switch on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_oe_q <= 1'b0;
            cfg_oe_q   <= 1'b0;
        end else begin
            ratio_oe_q <= ratio_en_i;
            cfg_oe_q   <= cfg_en_i;
        end
    end

    // Gate the data with its enable.
    always_comb begin
        ratio_oe_o = ratio_oe_q;
        cfg_oe_o   = cfg_oe_q;
        ratio_o    = ratio_oe_q ? ratio_q : '0;
        cfg_o      = cfg_oe_q   ? cfg_q   : '0;
    end

    // R11
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_oe_o && $past(ratio_oe_o)) |-> $stable(ratio_o));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_o && $past(cfg_oe_o)) |-> $stable(cfg_o));

    // R4
    cfg_in_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_oe_o |-> ratio_oe_o);

endmodule

// File: rtl/warm_rst_seq.sv
// Module: warm_rst_seq (top)
// Sequences a warm reset with strap setup/hold windows, all in bus clocks:
// the ratio strap is driven on the reset-asserting edge, the other straps
// PRE_CLKS clocks before release, and both are held HOLD_CLKS after release.
// Assumes: pwr_good_i is synchronous to clk; HOLD_CLKS is 2 or 3;
// RST_CLKS >= PRE_CLKS + 2 (smaller values are stretched to that).
module warm_rst_seq
    import wrs_pkg::*;
#(
    parameter int CLK_HZ     = 266_666_666,
    parameter int MIN_RST_US = 1000,
    parameter int PRE_CLKS   = 4,
    parameter int HOLD_CLKS  = 3,
    parameter int RATIO_W    = 5,
    parameter int CFG_W      = 8,
    parameter int SYNC_STG   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               warm_req_i,
    input  logic               pwr_good_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [CFG_W-1:0]   cfg_i,
    output logic               reset_n_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               ratio_oe_o,
    output logic [CFG_W-1:0]   cfg_o,
    output logic               cfg_oe_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               pg_err_o
);

    localparam longint RST_CLKS_L = (longint'(CLK_HZ) * MIN_RST_US) / 1_000_000;
    localparam int RST_CLKS  = int'(RST_CLKS_L);
    localparam int HOLD_LEN  = (RST_CLKS > PRE_CLKS + 1) ? RST_CLKS - 1 - PRE_CLKS : 1;
    localparam int KEEP_LEN  = (HOLD_CLKS > 1) ? HOLD_CLKS - 1 : 1;
    localparam int MAX_A     = (HOLD_LEN > PRE_CLKS) ? HOLD_LEN : PRE_CLKS;
    localparam int MAX_LEN   = (MAX_A > KEEP_LEN) ? MAX_A : KEEP_LEN;
    localparam int TW        = $clog2(MAX_LEN + 1);

    wrs_state_e    state_q, state_d;
    logic          req_pulse;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          abort;
    logic          abort_hold_q, abort_hold_d;
    logic          reset_n_q, reset_n_d;
    logic          busy_q, busy_d;
    logic          done_q, done_d;
    logic          err_q;
    logic          ratio_en, cfg_en, capture;

    wrs_req_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (warm_req_i),
        .pulse_o (req_pulse)
    );

    wrs_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    // Next-phase decision, phase timer loading and power-good abort.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        abort    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_pulse && pwr_good_i) state_d = ST_RATIO;
            end
            ST_RATIO: begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(HOLD_LEN - 1);
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    state_d  = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PRE_CLKS - 1);
                end
            end
            ST_PRE: begin
                if (tmr_zero) state_d = ST_REL;
            end
            ST_REL: begin
                state_d  = ST_KEEP;
                tmr_load = 1'b1;
                tmr_val  = TW'(KEEP_LEN - 1);
            end
            ST_KEEP: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_q != ST_IDLE && !pwr_good_i) begin
            state_d  = ST_IDLE;
            tmr_load = 1'b0;
            abort    = 1'b1;
        end
    end

    // Output intent derived from the next phase, registered below.
    always_comb begin
        capture      = (state_q == ST_IDLE) && (state_d == ST_RATIO);
        ratio_en     = (state_d != ST_IDLE);
        cfg_en       = (state_d == ST_PRE) || (state_d == ST_REL) || (state_d == ST_KEEP);
        abort_hold_d = abort ? 1'b1 : ((state_d == ST_REL) ? 1'b0 : abort_hold_q);
        reset_n_d    = pwr_good_i && !abort_hold_d &&
                       !((state_d == ST_RATIO) || (state_d == ST_HOLD) || (state_d == ST_PRE));
        busy_d       = (state_d != ST_IDLE);
        done_d       = (state_q == ST_KEEP) && (state_d == ST_IDLE) && !abort;
    end

    // Phase register and registered control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            abort_hold_q <= 1'b0;
            reset_n_q    <= 1'b0;
            busy_q       <= 1'b0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            state_q      <= state_d;
            abort_hold_q <= abort_hold_d;
            reset_n_q    <= reset_n_d;
            busy_q       <= busy_d;
            done_q       <= done_d;
            err_q        <= err_q | abort;
        end
    end

    wrs_strap_out #(.RATIO_W(RATIO_W), .CFG_W(CFG_W)) u_straps (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .ratio_i    (ratio_i),
        .cfg_i      (cfg_i),
        .ratio_en_i (ratio_en),
        .cfg_en_i   (cfg_en),
        .ratio_o    (ratio_o),
        .ratio_oe_o (ratio_oe_o),
        .cfg_o      (cfg_o),
        .cfg_oe_o   (cfg_oe_o)
    );

    // Drive the control ports from their registers.
    always_comb begin
        reset_n_o = reset_n_q;
        busy_o    = busy_q;
        done_o    = done_q;
        pg_err_o  = err_q;
    end

    // R2
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!reset_n_o && ratio_oe_o && !cfg_oe_o));

    // R4
    release_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reset_n_o) && busy_o) |-> (cfg_oe_o && ratio_oe_o));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !ratio_oe_o && !cfg_oe_o));

    // R9
    pg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !pwr_good_i) |=> (!busy_o && !ratio_oe_o && !reset_n_o && pg_err_o));

    // R8
    pg_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !pwr_good_i) |=> (!busy_o && !reset_n_o));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_err_o |=> pg_err_o);

endmodule

// File: tb/warm_rst_seq_tb.sv
// Directed bench for warm_rst_seq: one task per scenario, each self-checking.
module warm_rst_seq_tb;

    localparam int CLK_HZ = 50_000;
    localparam int PRE    = 4;
    localparam int HN     = 3;
    localparam int RW     = 5;
    localparam int CW     = 6;
    localparam int RST    = 50;   // 50000 Hz * 1 ms

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          warm_req_i = 1'b0;
    logic          pwr_good_i = 1'b1;
    logic [RW-1:0] ratio_i = '0;
    logic [CW-1:0] cfg_i = '0;
    logic          reset_n_o;
    logic [RW-1:0] ratio_o;
    logic          ratio_oe_o;
    logic [CW-1:0] cfg_o;
    logic          cfg_oe_o;
    logic          busy_o;
    logic          done_o;
    logic          pg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    warm_rst_seq #(
        .CLK_HZ(CLK_HZ), .MIN_RST_US(1000), .PRE_CLKS(PRE), .HOLD_CLKS(HN),
        .RATIO_W(RW), .CFG_W(CW), .SYNC_STG(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .warm_req_i(warm_req_i), .pwr_good_i(pwr_good_i),
        .ratio_i(ratio_i), .cfg_i(cfg_i), .reset_n_o(reset_n_o), .ratio_o(ratio_o),
        .ratio_oe_o(ratio_oe_o), .cfg_o(cfg_o), .cfg_oe_o(cfg_oe_o),
        .busy_o(busy_o), .done_o(done_o), .pg_err_o(pg_err_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Raise the request and wait for busy; returns negedges counted.
    task automatic start_req(output int lat);
        lat = 0;
        @(negedge clk);
        warm_req_i = 1'b1;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            lat++;
            if (busy_o) break;
        end
    endtask

    // Trace a full sequence clock by clock. kind 0: plain, 1: re-request
    // mid-sequence, 2: change strap inputs mid-sequence.
    task automatic run_seq(input int kind, input logic [RW-1:0] r, input logic [CW-1:0] c);
        int lat;
        ratio_i = r;
        cfg_i   = c;
        start_req(lat);
        // R2: third edge after the request rises
        chk(lat == 3, "R2 start latency", lat, 3);
        chk(!reset_n_o && ratio_oe_o && !cfg_oe_o, "R2 start edge",
            {reset_n_o, ratio_oe_o, cfg_oe_o}, 3'b010);
        for (int i = 0; i < RST + HN + 6; i++) begin
            if (i > 0) @(negedge clk);
            chk(reset_n_o == (i >= RST), "R3 reset width", reset_n_o, int'(i >= RST));
            chk(cfg_oe_o == (i >= RST - PRE && i < RST + HN), "R4 cfg window",
                cfg_oe_o, int'(i >= RST - PRE && i < RST + HN));
            chk(ratio_oe_o == (i < RST + HN), "R5 ratio window", ratio_oe_o, int'(i < RST + HN));
            chk(done_o == (i == RST + HN), "R6 done pulse", done_o, int'(i == RST + HN));
            chk(busy_o == (i < RST + HN), "R7 R12 busy span", busy_o, int'(i < RST + HN));
            if (i < RST + HN)
                chk(ratio_o == r, "R11 ratio data", ratio_o, r);
            if (i >= RST - PRE && i < RST + HN)
                chk(cfg_o == c, "R11 cfg data", cfg_o, c);
            if (kind == 1 && i == 5)  warm_req_i = 1'b0;
            if (kind == 1 && i == 12) warm_req_i = 1'b1;
            if (kind == 2 && i == 10) begin
                ratio_i = ~r;
                cfg_i   = ~c;
            end
        end
        warm_req_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1
        chk(reset_n_o == 1'b1, "R1 reset_n", reset_n_o, 1);
        chk(!ratio_oe_o && !cfg_oe_o, "R1 enables", {ratio_oe_o, cfg_oe_o}, 0);
        chk(!busy_o && !done_o && !pg_err_o, "R1 flags", {busy_o, done_o, pg_err_o}, 0);
    endtask

    task automatic t_pg_low_idle();
        pwr_good_i = 1'b0;
        repeat (2) @(negedge clk);
        // R8
        chk(reset_n_o == 1'b0, "R8 reset held", reset_n_o, 0);
        warm_req_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(busy_o == 1'b0, "R8 request ignored", busy_o, 0);
        warm_req_i = 1'b0;
        repeat (2) @(negedge clk);
        pwr_good_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0, "R8 not remembered", busy_o, 0);
        chk(reset_n_o == 1'b1, "R8 reset after pg", reset_n_o, 1);
        chk(pg_err_o == 1'b0, "R8 no error", pg_err_o, 0);
    endtask

    task automatic t_abort(input int at);
        int lat;
        ratio_i = 5'h0B;
        cfg_i   = 6'h2D;
        start_req(lat);
        for (int i = 1; i < at; i++) @(negedge clk);
        pwr_good_i = 1'b0;
        @(negedge clk);
        // R9
        chk(!busy_o && !ratio_oe_o && !cfg_oe_o, "R9 drivers off",
            {busy_o, ratio_oe_o, cfg_oe_o}, 0);
        chk(reset_n_o == 1'b0, "R9 reset low", reset_n_o, 0);
        chk(pg_err_o == 1'b1, "R9 error set", pg_err_o, 1);
        chk(done_o == 1'b0, "R9 no done", done_o, 0);
        warm_req_i = 1'b0;
        pwr_good_i = 1'b1;
        repeat (5) @(negedge clk);
        // R10
        chk(reset_n_o == 1'b0, "R10 reset kept", reset_n_o, 0);
        chk(pg_err_o == 1'b1, "R10 error sticky", pg_err_o, 1);
        chk(busy_o == 1'b0, "R10 idle", busy_o, 0);
        run_seq(0, 5'h11, 6'h05);
        chk(reset_n_o == 1'b1, "R10 released by sequence", reset_n_o, 1);
        chk(pg_err_o == 1'b1, "R10 error still set", pg_err_o, 1);
    endtask

    initial begin
        t_reset_state();
        run_seq(0, 5'h15, 6'h2A);   // plain sequence, request held high (R12)
        run_seq(0, 5'h0A, 6'h15);
        run_seq(2, 5'h1C, 6'h33);   // R11 inputs change mid-sequence
        run_seq(1, 5'h03, 6'h3C);   // R7 second edge mid-sequence
        t_pg_low_idle();
        t_abort(20);                // abort while holding reset
        t_abort(RST + 1);           // abort during strap hold
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule